// File: doc/BRIEF.md
# Serial Link Flow Control Unit

This unit decides, cycle by cycle, when a serial port may move characters out of its transmit queue, when its transmitter may begin shifting a character, and when its receiver may accept the next one. It sits between a character transmit FIFO, a transmitter that has one holding register and one shift register, and a receiver that reports each finished character. The unit handles two kinds of flow control. In the software kind, the far end sends stop and go characters inside the data stream. In the hardware kind, the link uses active-low clear-to-send, request-to-send and data-set-ready wires.

The software kind works as follows. A received stop character (0x13) freezes the transfer of characters from the FIFO into the transmitter. Characters that already sit in the holding and shift registers still drain, so at most two characters leave after the stop. Transfer resumes on a go character (0x11). It also resumes on a host transmit-enable command. In the open resume mode, it resumes on any received character other than a stop. Every received character goes on to the receive data path unchanged, flow-control characters included.

The hardware kind has three automatic modes. The clear-to-send check gates the start of each character. The request-to-send output follows the bursts taken from the FIFO. The data-set-ready check closes the receiver after any character that ends while data-set-ready is deasserted. Both incoming handshake wires pass through a two-flop synchronizer. The five mode bits sit in a configuration register that resets to zero.

Top module: `uart_flow_ctrl`

## Requirements
- R1: A configuration write (`cfg_wr`) loads `cfg_wdata`, with the bits laid out as follows. Bit 0 enables in-band flow control. Bit 1 selects the open resume mode. Bit 2 enables the automatic clear-to-send check. Bit 3 enables the automatic request-to-send output. Bit 4 enables the automatic data-set-ready check. After reset all bits are zero and the outputs read `rts_n`=0, `fifo_load_ok`=0, `tx_start_gnt`=0 and `rx_enable`=1.
- R2: With in-band control enabled, a received 0x13 drops `fifo_load_ok` from the next cycle. The character start handshake keeps working while transfer is halted.
- R3: With the open resume mode off, a halted unit resumes only on a received 0x11 or a `host_tx_enable` pulse. Any other received character, 0x13 included, leaves it halted.
- R4: With the open resume mode on, any received character other than 0x13 resumes a halted unit, and so does `host_tx_enable`.
- R5: With in-band control disabled, no received character halts transfer. Clearing the enable bit while halted raises `fifo_load_ok` in the cycle the write takes effect, and enabling it again does not bring back the halt.
- R6: With the clear-to-send check on, a start request that arrives while the synchronized `cts_n` is high is held until `cts_n` is low. `tx_start_gnt` rises three clock edges after `cts_n` falls. With the check off, `cts_n` has no effect on the grant, which rises one edge after the request.
- R7: Once raised, `tx_start_gnt` stays high until `tx_char_done`, whatever `cts_n` does. It falls one edge after `tx_char_done`.
- R8: With automatic request-to-send on, `rts_n` is low while a burst runs. The synchronized `cts_n` going high drives `rts_n` high at the third edge after the change, and FIFO loads continue until the FIFO is empty and no character is in flight. After that, loads stay blocked until `cts_n` is low again, and `rts_n` returns low one edge after the unit reaches idle.
- R9: With automatic request-to-send off, `rts_n` is held low.
- R10: With the data-set-ready check on, a character that ends while the synchronized `dsr_n` is high drops `rx_enable` on the next edge. `rx_enable` returns three edges after `dsr_n` falls. With the check off, `rx_enable` stays high.
- R11: `rx_fwd_valid` and `rx_fwd_data` equal `rx_valid` and `rx_data` in the same cycle, for flow-control characters too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration register |
| cfg_wdata | input | 5 | Configuration bits (layout in R1) |
| host_tx_enable | input | 1 | Host command pulse: restart transmission |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| fifo_nonempty | input | 1 | Transmit FIFO holds at least one character |
| fifo_load_ok | output | 1 | Transmitter may move a FIFO character into its holding register |
| tx_start_req | input | 1 | Transmitter has a character ready to shift; held until granted |
| tx_start_gnt | output | 1 | Shifting may proceed; held until the character ends |
| tx_char_done | input | 1 | Pulse: the character in the shift register has finished |
| rx_valid | input | 1 | Pulse: receiver finished a character |
| rx_data | input | 8 | Character from the receiver |
| rx_enable | output | 1 | Receiver may accept the next character |
| rx_fwd_valid | output | 1 | Forwarded character strobe |
| rx_fwd_data | output | 8 | Forwarded character |

## Verification
If the halt flag is wrong, `fifo_load_ok` shows it one edge after the offending received character. That is why the bench pairs a stop character with every possible follow-up character in both resume modes. A fault in the burst or character state machines appears on `rts_n`, `fifo_load_ok` or `tx_start_gnt` at a known edge count after a handshake wire moves. The synchronizer adds two of those edges, so the bench samples on both sides of the third edge to catch an extra or a missing stage. A receive-gate fault shows on `rx_enable` one edge after a character ends, or at the third edge after `dsr_n` falls.

// File: rtl/flowctl_pkg.sv
`timescale 1ns/1ps
package flowctl_pkg;

    // Configuration bits; bit 0 is inband, bit 4 is dsr_auto
    typedef struct packed {
        logic dsr_auto;
        logic rts_auto;
        logic cts_auto;
        logic any_resume;
        logic inband;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {IB_RUN, IB_HALT} ib_state_e;

    typedef enum logic [1:0] {
        BU_IDLE, BU_ACTIVE, BU_FINISH, BU_BLOCKED
    } burst_state_e;

    typedef enum logic [1:0] {CH_IDLE, CH_HOLD, CH_SHIFT} char_state_e;

    typedef enum logic {RX_OPEN, RX_CLOSED} rx_state_e;

endpackage

// File: rtl/flowctl_sync.sv
`timescale 1ns/1ps
module flowctl_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flowctl_inband.sv
`timescale 1ns/1ps
module flowctl_inband
    import flowctl_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] XON_CHAR  = 8'h11,
    parameter logic [DATA_W-1:0] XOFF_CHAR = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inband_en,
    input  logic              any_resume,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              host_tx_enable,
    output logic              halted
);
    ib_state_e state, nxt;
    logic      is_xon, is_xoff;

    assign is_xon  = (rx_data == XON_CHAR);
    assign is_xoff = (rx_data == XOFF_CHAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IB_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!inband_en) begin
            nxt = IB_RUN;
        end else begin
            unique case (state)
                IB_RUN: begin
                    if (rx_valid && is_xoff && !host_tx_enable) nxt = IB_HALT;
                end
                IB_HALT: begin
                    if (host_tx_enable)
                        nxt = IB_RUN;
                    else if (rx_valid && !is_xoff && (is_xon || any_resume))
                        nxt = IB_RUN;
                end
                default: nxt = IB_RUN;
            endcase
        end
    end

    // Dropping the enable releases the halt in the same cycle
    always_comb begin
        halted = (state == IB_HALT) && inband_en;
    end
endmodule

// File: rtl/flowctl_txgate.sv
`timescale 1ns/1ps
module flowctl_txgate
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_auto,
    input  logic rts_auto,
    input  logic cts_high,
    input  logic fifo_nonempty,
    input  logic halted,
    input  logic tx_start_req,
    input  logic tx_char_done,
    output logic tx_start_gnt,
    output logic fifo_load_ok,
    output logic rts_n
);
    burst_state_e bstate, bnxt;
    char_state_e  cstate, cnxt;
    logic         cts_block, start_hold, burst_done;

    assign cts_block  = rts_auto && cts_high;
    assign start_hold = cts_auto && cts_high;
    assign burst_done = !fifo_nonempty && (cstate == CH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bstate <= BU_IDLE;
            cstate <= CH_IDLE;
        end else begin
            bstate <= bnxt;
            cstate <= cnxt;
        end
    end

    // Burst tracking, drives request-to-send and FIFO loading
    always_comb begin
        bnxt = bstate;
        unique case (bstate)
            BU_IDLE:    if (fifo_nonempty && !cts_block) bnxt = BU_ACTIVE;
            BU_ACTIVE: begin
                if (cts_block)       bnxt = BU_FINISH;
                else if (burst_done) bnxt = BU_IDLE;
            end
            BU_FINISH: begin
                if (!rts_auto)       bnxt = BU_ACTIVE;
                else if (burst_done) bnxt = BU_BLOCKED;
            end
            BU_BLOCKED: if (!cts_block) bnxt = BU_IDLE;
            default:    bnxt = BU_IDLE;
        endcase
    end

    // Per-character start gating
    always_comb begin
        cnxt = cstate;
        unique case (cstate)
            CH_IDLE: begin
                if (tx_start_req) cnxt = start_hold ? CH_HOLD : CH_SHIFT;
            end
            CH_HOLD:  if (!start_hold)  cnxt = CH_SHIFT;
            CH_SHIFT: if (tx_char_done) cnxt = CH_IDLE;
            default:  cnxt = CH_IDLE;
        endcase
    end

    always_comb begin
        tx_start_gnt = (cstate == CH_SHIFT);
        fifo_load_ok = !halted &&
                       ((bstate == BU_ACTIVE) || (bstate == BU_FINISH));
        rts_n        = rts_auto ? (bstate != BU_ACTIVE) : 1'b0;
    end
endmodule

// File: rtl/flowctl_rxgate.sv
`timescale 1ns/1ps
module flowctl_rxgate
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dsr_auto,
    input  logic dsr_high,
    input  logic rx_valid,
    output logic rx_enable
);
    rx_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_OPEN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_OPEN:   if (rx_valid && dsr_auto && dsr_high) nxt = RX_CLOSED;
            RX_CLOSED: if (!dsr_auto || !dsr_high)           nxt = RX_OPEN;
            default:   nxt = RX_OPEN;
        endcase
    end

    always_comb begin
        rx_enable = (state == RX_OPEN) || !dsr_auto;
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
`timescale 1ns/1ps
module uart_flow_ctrl
    import flowctl_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] XON_CHAR    = 8'h11,
    parameter logic [DATA_W-1:0] XOFF_CHAR   = 8'h13,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              host_tx_enable,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              rts_n,
    input  logic              fifo_nonempty,
    output logic              fifo_load_ok,
    input  logic              tx_start_req,
    output logic              tx_start_gnt,
    input  logic              tx_char_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_enable,
    output logic              rx_fwd_valid,
    output logic [DATA_W-1:0] rx_fwd_data
);
    cfg_t cfg_q;
    logic cts_high, dsr_high, halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata);
    end

    flowctl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_high)
    );

    flowctl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dsr_sync (
        .clk(clk), .rst_n(rst_n), .d(dsr_n), .q(dsr_high)
    );

    flowctl_inband #(
        .DATA_W(DATA_W), .XON_CHAR(XON_CHAR), .XOFF_CHAR(XOFF_CHAR)
    ) u_inband (
        .clk(clk), .rst_n(rst_n),
        .inband_en(cfg_q.inband), .any_resume(cfg_q.any_resume),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .host_tx_enable(host_tx_enable), .halted(halted)
    );

    flowctl_txgate u_txgate (
        .clk(clk), .rst_n(rst_n),
        .cts_auto(cfg_q.cts_auto), .rts_auto(cfg_q.rts_auto),
        .cts_high(cts_high), .fifo_nonempty(fifo_nonempty),
        .halted(halted), .tx_start_req(tx_start_req),
        .tx_char_done(tx_char_done), .tx_start_gnt(tx_start_gnt),
        .fifo_load_ok(fifo_load_ok), .rts_n(rts_n)
    );

    flowctl_rxgate u_rxgate (
        .clk(clk), .rst_n(rst_n),
        .dsr_auto(cfg_q.dsr_auto), .dsr_high(dsr_high),
        .rx_valid(rx_valid), .rx_enable(rx_enable)
    );

    // Flow-control characters are passed on like any other
    assign rx_fwd_valid = rx_valid;
    assign rx_fwd_data  = rx_data;
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
`timescale 1ns/1ps
module uart_flow_ctrl_chk
    import flowctl_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] XOFF_CHAR = 8'h13
) (
    input logic              clk,
    input logic              rst_n,
    input cfg_t              cfg_q,
    input logic              cfg_wr,
    input logic              cts_high,
    input logic              halted,
    input logic              host_tx_enable,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              fifo_load_ok,
    input logic              tx_start_gnt,
    input logic              tx_char_done,
    input logic              rts_n,
    input logic              rx_enable
);
    // R2
    a_r2_xoff_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.inband && !cfg_wr && rx_valid && rx_data == XOFF_CHAR &&
         !host_tx_enable) |=> !fifo_load_ok);

    // R3
    a_r3_host_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_enable && cfg_q.inband && !cfg_wr) |=> !halted);

    // R5
    a_r5_off_never_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.inband |-> !halted);

    // R6
    a_r6_grant_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_start_gnt) && $past(cfg_q.cts_auto)) |-> !$past(cts_high));

    // R7
    a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_gnt && !tx_char_done) |=> tx_start_gnt);

    // R9
    a_r9_rts_manual_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.rts_auto |-> !rts_n);

    // R10
    a_r10_rx_open_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.dsr_auto |-> rx_enable);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
    .DATA_W(DATA_W), .XOFF_CHAR(XOFF_CHAR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cfg_wr(cfg_wr),
    .cts_high(cts_high), .halted(halted), .host_tx_enable(host_tx_enable),
    .rx_valid(rx_valid), .rx_data(rx_data), .fifo_load_ok(fifo_load_ok),
    .tx_start_gnt(tx_start_gnt), .tx_char_done(tx_char_done),
    .rts_n(rts_n), .rx_enable(rx_enable)
);

// File: tb/uart_flow_ctrl_test.sv
`timescale 1ns/1ps
module uart_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       host_tx_enable = 1'b0;
    logic       cts_n = 1'b0;
    logic       dsr_n = 1'b0;
    logic       rts_n;
    logic       fifo_nonempty = 1'b0;
    logic       fifo_load_ok;
    logic       tx_start_req = 1'b0;
    logic       tx_start_gnt;
    logic       tx_char_done = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_enable;
    logic       rx_fwd_valid;
    logic [7:0] rx_fwd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    uart_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .host_tx_enable(host_tx_enable), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .fifo_nonempty(fifo_nonempty),
        .fifo_load_ok(fifo_load_ok), .tx_start_req(tx_start_req),
        .tx_start_gnt(tx_start_gnt), .tx_char_done(tx_char_done),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_enable(rx_enable),
        .rx_fwd_valid(rx_fwd_valid), .rx_fwd_data(rx_fwd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [4:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    // One received character; forwarding checked in the same cycle (R11)
    task automatic send_rx(input logic [7:0] c);
        rx_valid = 1'b1; rx_data = c;
        #1;
        chk("R11 fwd data", rx_fwd_data, c);
        chk("R11 fwd valid", {7'd0, rx_fwd_valid}, 8'd1);
        tick(1);
        rx_valid = 1'b0;
    endtask

    task automatic host_pulse();
        host_tx_enable = 1'b1;
        tick(1);
        host_tx_enable = 1'b0;
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rts_n", {7'd0, rts_n}, 8'd0);
        chk("R1 load_ok", {7'd0, fifo_load_ok}, 8'd0);
        chk("R1 gnt", {7'd0, tx_start_gnt}, 8'd0);
        chk("R1 rx_enable", {7'd0, rx_enable}, 8'd1);
        tick(3);
        fifo_nonempty = 1'b1;
        tick(1);
        chk("R1 burst starts", {7'd0, fifo_load_ok}, 8'd1);

        // R3 / R4 sweep over every follow-up character in both resume modes
        for (int ar = 0; ar < 2; ar++) begin
            write_cfg(ar != 0 ? 5'b00011 : 5'b00001);
            for (int c = 0; c < 256; c++) begin
                send_rx(8'h13);
                chk("R2 xoff halts", {7'd0, fifo_load_ok}, 8'd0);
                send_rx(8'(c));
                chk(ar != 0 ? "R4 any resume" : "R3 xon resume",
                    {7'd0, fifo_load_ok},
                    {7'd0, (c != 8'h13) && (ar != 0 || c == 8'h11)});
                if (!fifo_load_ok) begin
                    host_pulse();
                    chk("R3 host resume", {7'd0, fifo_load_ok}, 8'd1);
                end
            end
        end

        // R2 start handshake still works while halted
        write_cfg(5'b00001);
        send_rx(8'h13);
        tx_start_req = 1'b1;
        tick(1);
        chk("R2 gnt while halted", {7'd0, tx_start_gnt}, 8'd1);
        chk("R2 still halted", {7'd0, fifo_load_ok}, 8'd0);
        tx_start_req = 1'b0;
        tx_char_done = 1'b1;
        tick(1);
        tx_char_done = 1'b0;
        chk("R7 gnt drops after done", {7'd0, tx_start_gnt}, 8'd0);

        // R5 clearing enable while halted, then re-enabling
        write_cfg(5'b00000);
        chk("R5 clear releases", {7'd0, fifo_load_ok}, 8'd1);
        write_cfg(5'b00001);
        chk("R5 halt not restored", {7'd0, fifo_load_ok}, 8'd1);

        // R5 in-band off: no character halts
        write_cfg(5'b00000);
        for (int c = 0; c < 256; c++) begin
            send_rx(8'(c));
            chk("R5 disabled no halt", {7'd0, fifo_load_ok}, 8'd1);
        end

        // R6 / R7 clear-to-send gating of character starts
        write_cfg(5'b00100);
        cts_n = 1'b1;
        tick(3);
        tx_start_req = 1'b1;
        tick(1);
        chk("R6 held while cts high", {7'd0, tx_start_gnt}, 8'd0);
        tick(4);
        chk("R6 still held", {7'd0, tx_start_gnt}, 8'd0);
        cts_n = 1'b0;
        tick(2);
        chk("R6 before sync latency", {7'd0, tx_start_gnt}, 8'd0);
        tick(1);
        chk("R6 granted after cts low", {7'd0, tx_start_gnt}, 8'd1);
        tx_start_req = 1'b0;
        cts_n = 1'b1;
        tick(4);
        chk("R7 grant kept", {7'd0, tx_start_gnt}, 8'd1);
        tx_char_done = 1'b1;
        tick(1);
        tx_char_done = 1'b0;
        chk("R7 grant released", {7'd0, tx_start_gnt}, 8'd0);
        write_cfg(5'b00000);
        tx_start_req = 1'b1;
        tick(1);
        chk("R6 cts ignored when off", {7'd0, tx_start_gnt}, 8'd1);
        chk("R9 rts low with cts high", {7'd0, rts_n}, 8'd0);
        tx_start_req = 1'b0;
        tx_char_done = 1'b1;
        tick(1);
        tx_char_done = 1'b0;
        cts_n = 1'b0;
        tick(3);

        // R8 automatic request-to-send through a burst
        write_cfg(5'b01000);
        chk("R8 rts low in burst", {7'd0, rts_n}, 8'd0);
        cts_n = 1'b1;
        tick(2);
        chk("R8 rts before sync", {7'd0, rts_n}, 8'd0);
        tick(1);
        chk("R8 rts high on cts", {7'd0, rts_n}, 8'd1);
        chk("R8 burst continues", {7'd0, fifo_load_ok}, 8'd1);
        fifo_nonempty = 1'b0;
        tick(1);
        fifo_nonempty = 1'b1;
        tick(1);
        chk("R8 blocked after burst", {7'd0, fifo_load_ok}, 8'd0);
        chk("R8 rts stays high", {7'd0, rts_n}, 8'd1);
        cts_n = 1'b0;
        tick(3);
        chk("R8 idle rts high", {7'd0, rts_n}, 8'd1);
        tick(1);
        chk("R8 new burst rts", {7'd0, rts_n}, 8'd0);
        chk("R8 new burst loads", {7'd0, fifo_load_ok}, 8'd1);
        write_cfg(5'b00000);
        chk("R9 rts low when off", {7'd0, rts_n}, 8'd0);

        // R10 data-set-ready receive gating
        write_cfg(5'b10000);
        dsr_n = 1'b1;
        tick(3);
        send_rx(8'h41);
        chk("R10 closed after char", {7'd0, rx_enable}, 8'd0);
        tick(2);
        chk("R10 stays closed", {7'd0, rx_enable}, 8'd0);
        dsr_n = 1'b0;
        tick(2);
        chk("R10 before sync", {7'd0, rx_enable}, 8'd0);
        tick(1);
        chk("R10 reopened", {7'd0, rx_enable}, 8'd1);
        send_rx(8'h42);
        chk("R10 dsr low keeps open", {7'd0, rx_enable}, 8'd1);
        write_cfg(5'b00000);
        dsr_n = 1'b1;
        tick(3);
        send_rx(8'h43);
        chk("R10 ignored when off", {7'd0, rx_enable}, 8'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule